// File: doc/BRIEF.md
# Partitioned Packed-Integer Vector Adder

This block adds two wide operands as a vector of independent integer lanes. A single row of byte-wide adder slices is joined by carry links, and a runtime lane-size selector decides which of those links are severed. The same hardware therefore performs eight 8-bit, four 16-bit or two 32-bit additions on a 64-bit datapath, and every lane wraps around modulo two to the power of its own width.

The datapath width is a parameter. Built at 128 bits, the same selector logic yields sixteen, eight or four lanes with no other change. A second parameter places an output register after the adder. With the register present, the output stage is a two-state machine: `ST_EMPTY` (no result held this cycle, `out_valid` low) and `ST_FULL` (a result captured on the previous edge, `out_valid` high). The transition `CAPTURE` (any state to `ST_FULL`) happens on every clock edge where `in_valid` is high and loads the new sum; the transition `DRAIN` (any state to `ST_EMPTY`) happens on every edge where `in_valid` is low and leaves the held sum untouched.

Top module: `simd_packed_add`

## Requirements
- R1: With `lane_sel` = 2'b00 the result is made of byte lanes: each 8-bit field of `sum` equals the sum of the matching 8-bit fields of `opa` and `opb`, modulo 256.
- R2: With `lane_sel` = 2'b01 each 16-bit field of `sum` equals the sum of the matching 16-bit fields of the operands, modulo 65536.
- R3: With `lane_sel` = 2'b10 each 32-bit field of `sum` equals the sum of the matching 32-bit fields of the operands, modulo 2^32.
- R4: The code `lane_sel` = 2'b11 is reserved and gives exactly the 32-bit lane result of R3.
- R5: No carry leaves a lane: an all-ones lane plus one yields zero in that lane and leaves the next lane unchanged, in every lane size.
- R6: Lane 0 sits at bit 0 of the vectors and the lanes follow one another without gaps toward the most significant bit.
- R7: While `rst_n` is low, `out_valid` is 0 and `sum` is all zeros.
- R8: With the output register enabled, `out_valid` rises one cycle after `in_valid` is high, and `sum` then carries the packed sum of the operands and lane size presented in that cycle; back-to-back inputs yield back-to-back results.
- R9: In a cycle where `in_valid` is low, the operands and lane size are ignored: on the next edge `out_valid` goes to 0 and `sum` keeps its previous value.
- R10: Built with `WIDTH` = 128, the block produces 16 byte lanes, 8 halfword lanes or 4 word lanes under the same lane-size codes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and lane size are valid this cycle |
| lane_sel | input | 2 | Lane size: 00 byte, 01 halfword, 10 word, 11 reserved (word) |
| opa | input | WIDTH | First packed operand |
| opb | input | WIDTH | Second packed operand |
| out_valid | output | 1 | `sum` holds a fresh result |
| sum | output | WIDTH | Packed lane-wise sum |

## Verification
On every accepted cycle the assertions check that the lowest byte lane is always an isolated 8-bit sum, that the lane just above a cut boundary is an isolated sum in each lane size including the reserved code, and that the output register follows `in_valid` by one cycle and holds its value when idle. Whether every lane of the vector is correct at once, whether the 128-bit build splits into the right number of lanes, and whether all-ones operands really stop at each boundary can only be shown by the bench's directed and random scenarios, which compare both the 64-bit and the 128-bit builds against a behavioural lane model on every clock.

// File: rtl/simd_add_pkg.sv
package simd_add_pkg;

    // Lane-size selector codes; the reserved code behaves as word lanes.
    typedef enum logic [1:0] {
        LM_B8  = 2'b00,
        LM_H16 = 2'b01,
        LM_W32 = 2'b10,
        LM_RSV = 2'b11
    } lane_mode_e;

    // Output register occupancy.
    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } ostate_e;

    localparam int unsigned SLICE_W = 8;

endpackage

// File: rtl/simd_cut_map.sv
// Decides, for each byte boundary, whether the carry link is severed.
module simd_cut_map
    import simd_add_pkg::*;
#(
    parameter int unsigned NSLICE = 8
) (
    input  lane_mode_e         mode,
    output logic [NSLICE-1:1]  cut
);

    localparam int unsigned PER_H16 = 2;
    localparam int unsigned PER_W32 = 4;

    always_comb begin
        cut = '0;
        unique case (mode)
            LM_B8: begin
                for (int k = 1; k < NSLICE; k++) cut[k] = 1'b1;
            end
            LM_H16: begin
                for (int k = 1; k < NSLICE; k++) cut[k] = ((k % PER_H16) == 0);
            end
            LM_W32, LM_RSV: begin
                for (int k = 1; k < NSLICE; k++) cut[k] = ((k % PER_W32) == 0);
            end
        endcase
    end

endmodule

// File: rtl/simd_slice_chain.sv
// Row of byte slices joined by carry links that the cut map may sever.
module simd_slice_chain
    import simd_add_pkg::*;
#(
    parameter int unsigned WIDTH = 64
) (
    input  logic [WIDTH-1:0]            a,
    input  logic [WIDTH-1:0]            b,
    input  logic [WIDTH/SLICE_W-1:1]    cut,
    output logic [WIDTH-1:0]            s
);

    localparam int unsigned NSLICE = WIDTH / SLICE_W;

    logic [NSLICE-1:0] cin;
    logic [NSLICE-2:0] cout;

    assign cin[0] = 1'b0;

    for (genvar k = 0; k < NSLICE; k++) begin : g_slice
        logic [SLICE_W-1:0] sa;
        logic [SLICE_W-1:0] sb;
        assign sa = a[k*SLICE_W +: SLICE_W];
        assign sb = b[k*SLICE_W +: SLICE_W];

        if (k > 0) begin : g_link
            assign cin[k] = cut[k] ? 1'b0 : cout[k-1];
        end

        if (k < NSLICE - 1) begin : g_mid
            logic [SLICE_W:0] part;
            assign part = {1'b0, sa} + {1'b0, sb} + {{SLICE_W{1'b0}}, cin[k]};
            assign s[k*SLICE_W +: SLICE_W] = part[SLICE_W-1:0];
            assign cout[k] = part[SLICE_W];
        end else begin : g_top
            assign s[k*SLICE_W +: SLICE_W] = sa + sb + {{(SLICE_W-1){1'b0}}, cin[k]};
        end
    end

endmodule

// File: rtl/simd_out_stage.sv
// Optional result register with a one-cycle valid pipeline.
module simd_out_stage
    import simd_add_pkg::*;
#(
    parameter int unsigned WIDTH   = 64,
    parameter bit          REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] d_sum,
    output logic             out_valid,
    output logic [WIDTH-1:0] q_sum
);

    if (REG_OUT) begin : g_reg
        ostate_e          state;
        ostate_e          state_nx;
        logic [WIDTH-1:0] held;

        always_comb begin
            state_nx = in_valid ? ST_FULL : ST_EMPTY;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                state <= ST_EMPTY;
            end else begin
                state <= state_nx;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                held <= '0;
            end else if (in_valid) begin
                held <= d_sum;
            end
        end

        always_comb begin
            q_sum = held;
            unique case (state)
                ST_EMPTY: out_valid = 1'b0;
                ST_FULL:  out_valid = 1'b1;
            endcase
        end

        AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid); // R8
        AST_RESULT_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> (q_sum == $past(d_sum))); // R8
        AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid); // R9
        AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> $stable(q_sum)); // R9
    end else begin : g_comb
        assign out_valid = in_valid;
        assign q_sum     = d_sum;
    end

endmodule

// File: rtl/simd_packed_add.sv
module simd_packed_add
    import simd_add_pkg::*;
#(
    parameter int unsigned WIDTH   = 64,
    parameter bit          REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [1:0]       lane_sel,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    output logic             out_valid,
    output logic [WIDTH-1:0] sum
);

    localparam int unsigned NSLICE = WIDTH / SLICE_W;

    lane_mode_e          mode;
    logic [NSLICE-1:1]   cut;
    logic [WIDTH-1:0]    add_sum;

    assign mode = lane_mode_e'(lane_sel);

    simd_cut_map #(.NSLICE(NSLICE)) u_cut (
        .mode (mode),
        .cut  (cut)
    );

    simd_slice_chain #(.WIDTH(WIDTH)) u_chain (
        .a   (opa),
        .b   (opb),
        .cut (cut),
        .s   (add_sum)
    );

    simd_out_stage #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .d_sum     (add_sum),
        .out_valid (out_valid),
        .q_sum     (sum)
    );

    // Lane checks on the adder output, taken across the first cut boundary.
    logic [7:0]  chk_b1;
    logic [15:0] chk_h1;
    logic [31:0] chk_w1;
    assign chk_b1 = opa[15:8]  + opb[15:8];
    assign chk_h1 = opa[31:16] + opb[31:16];
    assign chk_w1 = opa[63:32] + opb[63:32];

    AST_LANE0_AT_LSB: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (add_sum[7:0] == 8'(opa[7:0] + opb[7:0]))); // R6
    AST_BYTE_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lane_sel == 2'b00) |-> (add_sum[15:8] == chk_b1)); // R1
    AST_HALF_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lane_sel == 2'b01) |-> (add_sum[31:16] == chk_h1)); // R2
    AST_WORD_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lane_sel == 2'b10) |-> (add_sum[63:32] == chk_w1)); // R3
    AST_RSV_AS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lane_sel == 2'b11) |-> (add_sum[63:32] == chk_w1)); // R4

endmodule

// File: tb/simd_packed_add_tb_top.sv
module simd_packed_add_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [1:0]   lane_sel = 2'b00;
    logic [127:0] opa = '0;
    logic [127:0] opb = '0;

    logic         v64, v128;
    logic [63:0]  s64;
    logic [127:0] s128;

    int n_chk = 0;
    int n_bad = 0;

    string        cur_tag = "R8";
    string        exp_tag = "R7";
    logic         exp_v = 1'b0;
    logic [127:0] exp_s64 = '0;
    logic [127:0] exp_s128 = '0;

    always #2 clk = ~clk;

    simd_packed_add #(.WIDTH(64), .REG_OUT(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .lane_sel(lane_sel),
        .opa(opa[63:0]), .opb(opb[63:0]), .out_valid(v64), .sum(s64)
    );

    simd_packed_add #(.WIDTH(128), .REG_OUT(1'b1)) dut_w_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .lane_sel(lane_sel),
        .opa(opa), .opb(opb), .out_valid(v128), .sum(s128)
    );

    function automatic logic [127:0] ref_add(input logic [127:0] a, input logic [127:0] b,
                                             input logic [1:0] m, input int w);
        int lw;
        logic [127:0] msk, r, sa, sb;
        lw  = (m == 2'b00) ? 8 : (m == 2'b01) ? 16 : 32;
        msk = (128'd1 << lw) - 128'd1;
        r   = '0;
        for (int k = 0; k < w / lw; k++) begin
            sa = (a >> (k * lw)) & msk;
            sb = (b >> (k * lw)) & msk;
            r  = r | (((sa + sb) & msk) << (k * lw));
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural model of the registered output.
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_v    <= 1'b0;
            exp_s64  <= '0;
            exp_s128 <= '0;
            exp_tag  <= "R7";
        end else begin
            exp_v   <= in_valid;
            exp_tag <= in_valid ? cur_tag : "R9";
            if (in_valid) begin
                exp_s64  <= ref_add(opa, opb, lane_sel, 64);
                exp_s128 <= ref_add(opa, opb, lane_sel, 128);
            end
        end
    end

    // Compare on every clock, away from the active edge.
    always @(negedge clk) begin
        check({exp_tag, " valid"},     {127'd0, v64},  {127'd0, exp_v});
        check({exp_tag, " sum"},       {64'd0, s64},   exp_s64);
        check({"R10 ", exp_tag, " valid"}, {127'd0, v128}, {127'd0, exp_v});
        check({"R10 ", exp_tag, " sum"},   s128,          exp_s128);
    end

    task automatic drive(input logic v, input logic [1:0] m,
                         input logic [127:0] a, input logic [127:0] b, input string tag);
        @(negedge clk);
        in_valid = v;
        lane_sel = m;
        opa      = a;
        opb      = b;
        cur_tag  = tag;
    endtask

    function automatic string mode_tag(input logic [1:0] m);
        case (m)
            2'b00:   return "R1";
            2'b01:   return "R2";
            2'b10:   return "R3";
            default: return "R4";
        endcase
    endfunction

    logic [127:0] ones = '1;

    initial begin
        // R7: reset state while reset is held
        repeat (4) @(negedge clk);
        in_valid = 1'b1;
        opa = ones;
        opb = ones;
        @(posedge clk);
        @(negedge clk);
        check("R7 reset valid", {127'd0, v64}, 128'd0);
        check("R7 reset sum", {64'd0, s64}, 128'd0);
        in_valid = 1'b0;
        rst_n = 1'b1;

        // R5: all-ones lanes plus one, each lane size
        drive(1, 2'b00, ones, {16{8'h01}}, "R5");
        drive(1, 2'b01, ones, {8{16'h0001}}, "R5");
        drive(1, 2'b10, ones, {4{32'h0000_0001}}, "R5");
        drive(1, 2'b11, ones, {4{32'h0000_0001}}, "R5");
        // all-ones plus all-ones crosses every lane carry
        for (int m = 0; m < 4; m++) drive(1, 2'(m), ones, ones, "R5");
        // R6: marker in lane 0 lands at the LSB; alternating lanes
        drive(1, 2'b00, 128'h1, 128'h0, "R6");
        drive(1, 2'b01, {8{16'h00FF}}, {8{16'h0001}}, "R6");
        drive(1, 2'b00, {8{16'h00FF}}, {8{16'h0001}}, "R6");
        // R9: idle cycles with changing operands
        drive(0, 2'b00, ones, ones, "R9");
        drive(0, 2'b10, 128'h5, 128'h7, "R9");
        // R8: back-to-back results
        drive(1, 2'b10, 128'h1234, 128'h1, "R8");
        drive(1, 2'b00, 128'hFF, 128'h2, "R8");
        drive(0, 2'b00, 128'h0, 128'h0, "R9");

        // Random mix across all lane sizes
        for (int i = 0; i < 400; i++) begin
            logic [1:0] m;
            logic       v;
            m = 2'($urandom_range(0, 3));
            v = ($urandom_range(0, 5) != 0);
            drive(v, m, {$urandom, $urandom, $urandom, $urandom},
                  {$urandom, $urandom, $urandom, $urandom}, mode_tag(m));
        end
        drive(0, 2'b00, 128'h0, 128'h0, "R9");
        @(negedge clk);
        @(negedge clk);
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(4 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule